// File: doc/BRIEF.md
# SPI Transfer Status Flag Unit

This block builds the status word and the transmit-threshold interrupt for an SPI master controller. It reads event strobes and levels from the transfer engine: frame finished, chip select released, burst count reached, the transfer-enable bit, soft reset, the transmit FIFO fill level, whether the transmit shift register holds data, and whether the receive shift register is full. From these it keeps a configuration-lock flag, a transmit-running flag, a transmit-empty flag and two sticky event flags. Software clears the sticky flags by writing ones.

The lock flag tells software when it may change configuration registers. It is set when a transfer is enabled. It is released at a transfer boundary: a frame that finishes after the enable bit was cleared, or a burst that reaches its programmed count. The release is held back while data is stranded in the transmit FIFO or in the receive shift register. A release that arrives during such a hold is remembered and takes effect once the hold ends. A soft reset releases the lock at once.

The status word and the interrupt are registered. Every input is sampled on a rising clock edge, and the result appears after that same edge.

Top module: `spi_stat_flags`

## Requirements
- R1: After reset, every bit of `status` is 0 and `irq` is 0.
- R2: On a cycle where `xfer_en` is 1 and was 0 in the previous cycle, the lock flag `status[31]` is 1 from the next cycle on (soft reset excepted).
- R3: While locked, a release request sets `status[31]` to 0 in the next cycle unless a hold is active. A release request is `frame_done` with `xfer_en`=0, in either mode. A `frame_done` while `xfer_en`=1 with `burst_mode`=0 has no effect on the lock.
- R4: With `burst_mode`=1, `burst_done` is a release request even while `xfer_en` is still 1.
- R5: A hold is active while `tx_lvl` equals DEPTH or `rxsr_full` is 1. While a hold is active, `status[31]` stays 1. A release request seen during a hold is kept pending, and the lock drops in the cycle after the first cycle with no hold active.
- R6: `soft_rst` sets `status[31]`, `status[22]` and `status[21]` to 0 in the next cycle, whatever the hold state. It also discards any pending release.
- R7: `status[23]` equals `txsr_full` of the previous cycle. `status[20]` is 1 exactly when `tx_lvl` was 0 in the previous cycle.
- R8: The completion flag `status[22]` becomes 1 in the cycle after `cs_deassert`. A write (`wr_en`=1) with `wr_data[22]`=1 clears it. A write with `wr_data[22]`=0 leaves it unchanged. When a set and a clear meet in the same cycle, the flag ends up 1.
- R9: The threshold flag `status[21]` becomes 1 only when `tx_lvl` was `tx_thresh`+1 in one cycle and equals `tx_thresh` in the next. A rise to the threshold, or a jump down past `tx_thresh`+1, does not set it. It clears when written with `wr_data[21]`=1, and a set wins over a simultaneous clear.
- R10: `irq` is a one-cycle pulse, issued in the same cycle that the threshold flag is set, when `irq_en` was 1 at the crossing. While `irq` is 1, `status[21]` is 1.
- R11: `status[30:24]` and `status[19:0]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset strobe |
| xfer_en | input | 1 | Transfer-enable control bit |
| burst_mode | input | 1 | 1 = burst mode, 0 = continuous mode |
| frame_done | input | 1 | Strobe: current frame has finished |
| burst_done | input | 1 | Strobe: programmed transfer count reached |
| cs_deassert | input | 1 | Strobe: chip select released after the last frame |
| tx_lvl | input | LVL_W | Transmit FIFO fill level, 0..DEPTH |
| tx_thresh | input | LVL_W | Transmit FIFO interrupt threshold |
| txsr_full | input | 1 | Transmit shift register holds data |
| rxsr_full | input | 1 | Receive shift register full |
| irq_en | input | 1 | Threshold interrupt enable |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 32 | Write data; a 1 in bit 22 or bit 21 clears that flag |
| status | output | 32 | Status word |
| irq | output | 1 | Threshold interrupt pulse |

## Verification
A wrong internal state shows up on `status` one cycle after the stimulus that should have moved it. A lost pending release leaves bit 31 stuck at 1 after the hold has cleared. A forgotten hold drops bit 31 while the transmit FIFO is still full. A bad level history sets bit 21, or fires `irq`, on a jump or a rise instead of only on the one-step fall to the threshold. A wrong priority in the sticky logic shows as bit 22 or bit 21 reading 0 after a same-cycle set and clear.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned BIT_LOCK  = 31;
  localparam int unsigned BIT_RUN   = 23;
  localparam int unsigned BIT_DONE  = 22;
  localparam int unsigned BIT_THR   = 21;
  localparam int unsigned BIT_EMPTY = 20;
  localparam int unsigned N_STICKY  = 2;

  // Release request: a frame closes with the enable bit low, or a burst reaches its count.
  function automatic logic release_req(input logic frame_done, input logic xfer_en,
                                       input logic burst_mode, input logic burst_done);
    return (frame_done && !xfer_en) || (burst_mode && burst_done);
  endfunction
endpackage

// File: rtl/spi_stat_lock.sv
module spi_stat_lock #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             xfer_en,
  input  logic             rel_req,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic             rxsr_full,
  output logic             hold,
  output logic             en_rise,
  output logic             lock
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic en_q;
  logic pend;

  assign hold    = (tx_lvl == FULL_LVL) || rxsr_full;
  assign en_rise = xfer_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      lock <= 1'b0;
      pend <= 1'b0;
    end else begin
      en_q <= xfer_en;
      if (soft_rst) begin
        lock <= 1'b0;
        pend <= 1'b0;
      end else if (en_rise) begin
        lock <= 1'b1;
        pend <= 1'b0;
      end else if (lock && (rel_req || pend)) begin
        if (hold) begin
          pend <= 1'b1;
        end else begin
          lock <= 1'b0;
          pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_stat_sticky.sv
module spi_stat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_ev,
  input  logic clr_wr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (soft_rst)   flag <= 1'b0;
    else if (set_ev)     flag <= 1'b1;
    else if (clr_wr)     flag <= 1'b0;
  end
endmodule

// File: rtl/spi_stat_thr.sv
module spi_stat_thr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] tx_thresh,
  output logic             thr_evt,
  output logic             empty_q
);
  logic [LVL_W-1:0] lvl_q;

  // One-step fall from thresh+1 onto thresh; widened so thresh+1 cannot wrap.
  function automatic logic fell_onto(input logic [LVL_W-1:0] prev,
                                     input logic [LVL_W-1:0] cur,
                                     input logic [LVL_W-1:0] thr);
    return ({1'b0, prev} == ({1'b0, thr} + 1'b1)) && (cur == thr);
  endfunction

  assign thr_evt = !soft_rst && fell_onto(lvl_q, tx_lvl, tx_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      empty_q <= 1'b0;
    end else begin
      lvl_q   <= tx_lvl;
      empty_q <= (tx_lvl == '0);
    end
  end
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             xfer_en,
  input  logic             burst_mode,
  input  logic             frame_done,
  input  logic             burst_done,
  input  logic             cs_deassert,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic             txsr_full,
  input  logic             rxsr_full,
  input  logic             irq_en,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      status,
  output logic             irq
);
  import spi_stat_pkg::*;

  logic rel_req, hold, en_rise, lock;
  logic thr_evt, empty_q, run_q;
  logic [N_STICKY-1:0] set_vec, clr_vec, flag_vec;
  logic unused_wr;

  assign rel_req = release_req(frame_done, xfer_en, burst_mode, burst_done);
  assign unused_wr = ^{wr_data[31:23], wr_data[20:0]};

  spi_stat_lock #(.DEPTH(DEPTH)) lock_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_en(xfer_en),
    .rel_req(rel_req), .tx_lvl(tx_lvl), .rxsr_full(rxsr_full),
    .hold(hold), .en_rise(en_rise), .lock(lock)
  );

  spi_stat_thr #(.DEPTH(DEPTH)) thr_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_lvl(tx_lvl),
    .tx_thresh(tx_thresh), .thr_evt(thr_evt), .empty_q(empty_q)
  );

  // index 0: transfer complete, index 1: FIFO threshold
  assign set_vec = {thr_evt, cs_deassert};
  assign clr_vec = {wr_en && wr_data[BIT_THR], wr_en && wr_data[BIT_DONE]};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    spi_stat_sticky st_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .set_ev(set_vec[g]), .clr_wr(clr_vec[g]), .flag(flag_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      run_q <= txsr_full;
      irq   <= thr_evt && irq_en;
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_LOCK]  = lock;
    status[BIT_RUN]   = run_q;
    status[BIT_DONE]  = flag_vec[0];
    status[BIT_THR]   = flag_vec[1];
    status[BIT_EMPTY] = empty_q;
  end
endmodule

// File: rtl/spi_stat_flags_chk.sv
module spi_stat_flags_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             xfer_en,
  input logic             cs_deassert,
  input logic             txsr_full,
  input logic             irq_en,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      status,
  input logic             irq,
  input logic             hold,
  input logic             en_rise,
  input logic             thr_evt
);
  a_r2_enable_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !soft_rst) |=> status[31]);
  a_r5_hold_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31] && hold && !soft_rst) |=> status[31]);
  a_r6_soft_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!status[31] && !status[22] && !status[21]));
  a_r7_run_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    txsr_full |=> status[23]);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_deassert && !soft_rst) |=> status[22]);
  a_r8_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (status[22] && !(wr_en && wr_data[22]) && !soft_rst) |=> status[22]);
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_evt && irq_en) |=> irq);
  a_r10_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[21]);
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[30:24] == 7'd0) && (status[19:0] == 20'd0));
  logic unused_x;
  assign unused_x = xfer_en;
endmodule

bind spi_stat_flags spi_stat_flags_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_en(xfer_en),
  .cs_deassert(cs_deassert), .txsr_full(txsr_full), .irq_en(irq_en),
  .wr_en(wr_en), .wr_data(wr_data), .status(status), .irq(irq),
  .hold(hold), .en_rise(en_rise), .thr_evt(thr_evt)
);

// File: tb/spi_stat_flags_tb_top.sv
`timescale 1ns/1ps
module spi_stat_flags_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, xfer_en = 0, burst_mode = 0, frame_done = 0, burst_done = 0;
  logic cs_deassert = 0, txsr_full = 0, rxsr_full = 0, irq_en = 0, wr_en = 0;
  logic [LVL_W-1:0] tx_lvl = '0, tx_thresh = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_stat_flags #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_en(xfer_en),
    .burst_mode(burst_mode), .frame_done(frame_done), .burst_done(burst_done),
    .cs_deassert(cs_deassert), .tx_lvl(tx_lvl), .tx_thresh(tx_thresh),
    .txsr_full(txsr_full), .rxsr_full(rxsr_full), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, then sample just after the rising edge.
  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic drv();
    @(negedge clk);
  endtask
  task automatic clear_pulses();
    drv();
    frame_done = 0; burst_done = 0; cs_deassert = 0; soft_rst = 0; wr_en = 0; wr_data = '0;
  endtask
  task automatic lock_up();
    drv(); xfer_en = 1; tick();
    chk("R2 lock on enable rise", {31'd0, status[31]}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_continuous();
    lock_up();
    drv(); frame_done = 1; tick();
    chk("R3 frame with enable high keeps lock", {31'd0, status[31]}, 32'd1);
    drv(); frame_done = 0; xfer_en = 0; tick();
    drv(); frame_done = 1; tick();
    chk("R3 frame after enable clear releases", {31'd0, status[31]}, 32'd0);
    clear_pulses();
  endtask

  task automatic t_burst();
    drv(); burst_mode = 1;
    lock_up();
    drv(); burst_done = 1; tick();
    chk("R4 burst count releases", {31'd0, status[31]}, 32'd0);
    clear_pulses(); xfer_en = 0; burst_mode = 0;
  endtask

  task automatic t_hold();
    lock_up();
    drv(); xfer_en = 0; tx_lvl = LVL_W'(DEPTH); frame_done = 1; tick();
    chk("R5 full tx FIFO holds lock", {31'd0, status[31]}, 32'd1);
    clear_pulses(); tick();
    chk("R5 lock held while full", {31'd0, status[31]}, 32'd1);
    drv(); tx_lvl = LVL_W'(DEPTH - 1); tick();
    chk("R5 pending release after drain", {31'd0, status[31]}, 32'd0);
    lock_up();
    drv(); xfer_en = 0; rxsr_full = 1; frame_done = 1; tick();
    chk("R5 rx shift full holds lock", {31'd0, status[31]}, 32'd1);
    clear_pulses(); rxsr_full = 0; tick();
    chk("R5 release after rx shift drains", {31'd0, status[31]}, 32'd0);
  endtask

  task automatic t_soft();
    lock_up();
    drv(); xfer_en = 0; tx_lvl = LVL_W'(DEPTH); cs_deassert = 1; tick();
    drv(); cs_deassert = 0; soft_rst = 1; tick();
    chk("R6 soft reset clears lock and done", status & 32'h8060_0000, 32'd0);
    clear_pulses(); tx_lvl = 5; tick();
  endtask

  task automatic t_run();
    drv(); txsr_full = 1; tx_lvl = 0; tick();
    chk("R7 run and empty", status & 32'h0090_0000, 32'h0090_0000);
    drv(); txsr_full = 0; tx_lvl = 2; tick();
    chk("R7 run and empty cleared", status & 32'h0090_0000, 32'd0);
  endtask

  task automatic t_done();
    drv(); cs_deassert = 1; tick();
    chk("R8 done set", {31'd0, status[22]}, 32'd1);
    drv(); cs_deassert = 0; wr_en = 1; wr_data = 32'hFFBF_FFFF; tick();
    chk("R8 write 0 keeps done", {31'd0, status[22]}, 32'd1);
    drv(); wr_data = 32'h0040_0000; tick();
    chk("R8 write 1 clears done", {31'd0, status[22]}, 32'd0);
    drv(); cs_deassert = 1; tick();
    chk("R8 set wins over clear", {31'd0, status[22]}, 32'd1);
    clear_pulses(); wr_en = 1; wr_data = 32'h0040_0000; tick();
    clear_pulses();
  endtask

  task automatic t_thr();
    drv(); tx_thresh = 3; irq_en = 1; tx_lvl = 6; tick();
    drv(); tx_lvl = 5; tick();
    drv(); tx_lvl = 3; tick();
    chk("R9 jump past thresh+1 ignored", {30'd0, status[21], irq}, 32'd0);
    drv(); tx_lvl = 2; tick();
    drv(); tx_lvl = 3; tick();
    chk("R9 rise to thresh ignored", {30'd0, status[21], irq}, 32'd0);
    drv(); tx_lvl = 4; tick();
    drv(); tx_lvl = 3; tick();
    chk("R10 flag and irq on crossing", {30'd0, status[21], irq}, 32'd3);
    tick();
    chk("R10 irq is one cycle", {30'd0, status[21], irq}, 32'd2);
    drv(); wr_en = 1; wr_data = 32'h0020_0000; tick();
    chk("R9 write 1 clears flag", {31'd0, status[21]}, 32'd0);
    clear_pulses(); irq_en = 0; tx_lvl = 4; tick();
    drv(); tx_lvl = 3; wr_en = 1; wr_data = 32'h0020_0000; tick();
    chk("R9 set wins, no irq when disabled", {30'd0, status[21], irq}, 32'd2);
    chk("R11 reserved bits zero", status & 32'h7F0F_FFFF, 32'd0);
    clear_pulses();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    drv(); rst_n = 1; tx_lvl = 4; tick();
    t_continuous();
    t_burst();
    t_hold();
    t_soft();
    t_run();
    t_done();
    t_thr();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule